// File: doc/BRIEF.md
# Interrupt File Priority Selector

This block keeps a set of interrupt pages, one supervisor page followed by guest pages. Each page holds one pending bit and one enable bit for every interrupt identity, plus a threshold and a delivery-enable flag. For every page it finds the lowest-numbered identity that is both pending and enabled and that passes the threshold. It drives one interrupt line per page, which is high while delivery is on and such an identity exists.

Software reaches the per-page registers through a single read-modify-write port. In the same cycle, the port returns the old value and merges the write data under the write mask. A write with a nonzero mask to the top-identity register claims the current winner and clears its pending bit. Pending and enable bits are changed through a dedicated set port and a dedicated clear port, which are normally driven by message and register decode logic outside this block.

Top module: `intfile_prio_sel`

## Requirements
- R1: After reset every pending bit, enable bit, threshold and delivery flag is zero, every interrupt line is low and every register reads zero.
- R2: Identity 0 is never eligible, and set or clear requests for identity 0 or for identities at or above NUM_IDS change nothing. Among eligible identities, the lowest number that is both pending and enabled wins.
- R3: A threshold T with 0 < T <= NUM_IDS limits eligibility to identities below T. A threshold of zero or above NUM_IDS leaves every identity eligible.
- R4: The top-identity register (reg_sel = 2) reads the winner in bits 26:16 and again in bits 10:0, with all other bits zero. When no identity wins, it reads zero.
- R5: An access to the top-identity register with a nonzero mask clears the pending bit of the identity that wins in that cycle, whatever the write data. With a zero mask, or when nothing wins, no state changes.
- R6: Every access returns the old value, and the new value is (old & ~mask) | (data & mask) over the writable bits. The delivery register (reg_sel = 0) has only bit 0. The threshold register (reg_sel = 1) has bits 10:0. reg_sel = 3 reads zero and writes nothing.
- R7: irq_o[p] is the registered value of (delivery flag of p AND top identity of p nonzero). It changes one clock after the state it reflects.
- R8: Pages are independent of one another. A register access whose page index is NUM_PAGES or more reads zero and changes nothing.
- R9: The set port sets and the clear port clears one pending bit (kind 0) or one enable bit (kind 1). When both ports hit the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Set request valid |
| set_page | input | PW | Page of the set request |
| set_id | input | IDW | Identity of the set request |
| set_kind | input | 1 | 0 selects the pending bit, 1 selects the enable bit |
| clr_vld | input | 1 | Clear request valid |
| clr_page | input | PW | Page of the clear request |
| clr_id | input | IDW | Identity of the clear request |
| clr_kind | input | 1 | 0 selects the pending bit, 1 selects the enable bit |
| reg_vld | input | 1 | Register access valid |
| reg_page | input | PW | Page of the register access |
| reg_sel | input | 2 | 0 delivery, 1 threshold, 2 top identity, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Write mask |
| reg_rdata | output | 32 | Old register value, combinational |
| irq_o | output | NUM_PAGES | Per-page interrupt line |

## Verification
The bench builds the block with NUM_IDS = 40 and NUM_PAGES = 3. Because 40 is not a power of two, the identity ports can carry the out-of-range values 40 to 63. Thresholds of 39, 40 and 41 then fall on both sides of the NUM_IDS boundary. With three pages on a two-bit page index, page 3 exists on the port but not in the design, so the ignored-page case can be exercised, and the three real pages are enough to show that they stay independent.

// File: rtl/intfile_prio_sel.sv
module intfile_prio_sel #(
  parameter int NUM_IDS   = 64,
  parameter int NUM_PAGES = 4,
  localparam int IDW = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
  localparam int PW  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_vld,
  input  logic [PW-1:0]        set_page,
  input  logic [IDW-1:0]       set_id,
  input  logic                 set_kind,
  input  logic                 clr_vld,
  input  logic [PW-1:0]        clr_page,
  input  logic [IDW-1:0]       clr_id,
  input  logic                 clr_kind,
  input  logic                 reg_vld,
  input  logic [PW-1:0]        reg_page,
  input  logic [1:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  input  logic [31:0]          reg_wmask,
  output logic [31:0]          reg_rdata,
  output logic [NUM_PAGES-1:0] irq_o
);
  localparam int IW = 11;

  logic [NUM_PAGES-1:0][NUM_IDS-1:0] pend_q, pend_d, en_q, en_d;
  logic [NUM_PAGES-1:0][IW-1:0]      thr_q, thr_d, win;
  logic [NUM_PAGES-1:0]              dlv_q, dlv_d, irq_q;

  wire reg_ok = reg_vld && (32'(reg_page) < NUM_PAGES);
  wire set_ok = set_vld && (32'(set_page) < NUM_PAGES) && (set_id != '0) && (32'(set_id) < NUM_IDS);
  wire clr_ok = clr_vld && (32'(clr_page) < NUM_PAGES) && (clr_id != '0) && (32'(clr_id) < NUM_IDS);

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic [31:0] lim;
    assign lim = (thr_q[p] != '0 && 32'(thr_q[p]) <= NUM_IDS) ? 32'(thr_q[p]) : NUM_IDS;

    always_comb begin
      win[p] = '0;
      for (int i = NUM_IDS - 1; i >= 1; i--)
        if (pend_q[p][i] && en_q[p][i] && (32'(i) < lim)) win[p] = IW'(i);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[p] <= 1'b0;
      else        irq_q[p] <= dlv_q[p] && (win[p] != '0);
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_ok) begin
      case (reg_sel)
        2'd0:    reg_rdata = {31'b0, dlv_q[reg_page]};
        2'd1:    reg_rdata = {{(32-IW){1'b0}}, thr_q[reg_page]};
        2'd2:    reg_rdata = {5'b0, win[reg_page], 5'b0, win[reg_page]};
        default: reg_rdata = '0;
      endcase
    end
  end

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    thr_d  = thr_q;
    dlv_d  = dlv_q;
    if (reg_ok) begin
      case (reg_sel)
        2'd0: dlv_d[reg_page] = (dlv_q[reg_page] & ~reg_wmask[0]) | (reg_wdata[0] & reg_wmask[0]);
        2'd1: thr_d[reg_page] = (thr_q[reg_page] & ~reg_wmask[IW-1:0]) | (reg_wdata[IW-1:0] & reg_wmask[IW-1:0]);
        2'd2: if (reg_wmask != '0 && win[reg_page] != '0) pend_d[reg_page][win[reg_page]] = 1'b0;
        default: ;
      endcase
    end
    if (clr_ok) begin
      if (clr_kind) en_d[clr_page][clr_id]   = 1'b0;
      else          pend_d[clr_page][clr_id] = 1'b0;
    end
    if (set_ok) begin
      if (set_kind) en_d[set_page][set_id]   = 1'b1;
      else          pend_d[set_page][set_id] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
      dlv_q  <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
      dlv_q  <= dlv_d;
    end
  end
endmodule

// File: rtl/intfile_prio_sel_chk.sv
module intfile_prio_sel_chk #(
  parameter int NUM_IDS   = 64,
  parameter int NUM_PAGES = 4,
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_vld,
  input logic [PW-1:0]        reg_page,
  input logic [1:0]           reg_sel,
  input logic [31:0]          reg_rdata,
  input logic [NUM_PAGES-1:0] irq_o,
  input logic [NUM_PAGES-1:0] dlv_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk) $rose(rst_n) |-> irq_o == '0);

  assert_top_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && reg_sel == 2'd2) |->
      (reg_rdata[26:16] == reg_rdata[10:0] && reg_rdata[31:27] == 5'b0 && reg_rdata[15:11] == 5'b0));

  assert_top_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && reg_sel == 2'd2) |-> (32'(reg_rdata[10:0]) < NUM_IDS));

  assert_dlv_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && reg_sel == 2'd0) |-> reg_rdata[31:1] == '0);

  assert_thr_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && reg_sel == 2'd1) |-> reg_rdata[31:11] == '0);

  assert_bad_page_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && 32'(reg_page) >= NUM_PAGES) |-> reg_rdata == '0);

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_irq
    assert_irq_needs_dlv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[p] |-> $past(dlv_q[p]));
  end
endmodule

bind intfile_prio_sel intfile_prio_sel_chk #(.NUM_IDS(NUM_IDS), .NUM_PAGES(NUM_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_vld(reg_vld), .reg_page(reg_page), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .irq_o(irq_o), .dlv_q(dlv_q)
);

// File: tb/intfile_prio_sel_test.sv
`timescale 1ns/1ps
module intfile_prio_sel_test;
  localparam int NI = 40;
  localparam int NP = 3;
  localparam int IDW = $clog2(NI);
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_vld = 0, set_kind = 0, clr_vld = 0, clr_kind = 0, reg_vld = 0;
  logic [PW-1:0] set_page = '0, clr_page = '0, reg_page = '0;
  logic [IDW-1:0] set_id = '0, clr_id = '0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_wmask = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] irq_o;

  always #2 clk = ~clk;

  intfile_prio_sel #(.NUM_IDS(NI), .NUM_PAGES(NP)) uut (
    .clk(clk), .rst_n(rst_n),
    .set_vld(set_vld), .set_page(set_page), .set_id(set_id), .set_kind(set_kind),
    .clr_vld(clr_vld), .clr_page(clr_page), .clr_id(clr_id), .clr_kind(clr_kind),
    .reg_vld(reg_vld), .reg_page(reg_page), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  bit mp [NP][NI];
  bit me [NP][NI];
  logic [10:0] mthr [NP];
  bit mdl [NP];
  int nchk = 0, nfail = 0;
  bit done = 0;

  function automatic int m_win(int p);
    int lim = (mthr[p] != 0 && int'(mthr[p]) <= NI) ? int'(mthr[p]) : NI;
    for (int i = 1; i < lim; i++) if (mp[p][i] && me[p][i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] m_top(int p);
    logic [31:0] w = 32'(m_win(p));
    return (w << 16) | w;
  endfunction

  function automatic logic [31:0] m_read(int p, int sel);
    if (p >= NP) return 32'h0;
    case (sel)
      0: return {31'b0, mdl[p]};
      1: return {21'b0, mthr[p]};
      2: return m_top(p);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_op();
    @(negedge clk);
    set_vld = 0; clr_vld = 0; reg_vld = 0; reg_wmask = '0;
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      chk(irq_o[p] == (mdl[p] && m_win(p) != 0), "R7 irq line", 32'(irq_o[p]),
          32'(mdl[p] && m_win(p) != 0));
  endtask

  task automatic reg_op(int p, int sel, logic [31:0] d, logic [31:0] m, string tag);
    logic [31:0] exp;
    int w;
    @(negedge clk);
    reg_vld = 1; reg_page = PW'(p); reg_sel = 2'(sel); reg_wdata = d; reg_wmask = m;
    #1;
    exp = m_read(p, sel);
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    if (p < NP) begin
      case (sel)
        0: mdl[p] = (mdl[p] & ~m[0]) | (d[0] & m[0]);
        1: mthr[p] = (mthr[p] & ~m[10:0]) | (d[10:0] & m[10:0]);
        2: begin w = m_win(p); if (m != 0 && w != 0) mp[p][w] = 0; end
        default: ;
      endcase
    end
    finish_op();
  endtask

  task automatic bit_op(bit is_set, int p, int id, bit kind, bit also_other);
    @(negedge clk);
    if (is_set || also_other) begin
      set_vld = 1; set_page = PW'(p); set_id = IDW'(id); set_kind = kind;
    end
    if (!is_set || also_other) begin
      clr_vld = 1; clr_page = PW'(p); clr_id = IDW'(id); clr_kind = kind;
    end
    if (p < NP && id != 0 && id < NI) begin
      if (kind) me[p][id] = is_set || also_other;
      else      mp[p][id] = is_set || also_other;
    end
    finish_op();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin
      mdl[p] = 0; mthr[p] = '0;
      for (int i = 0; i < NI; i++) begin mp[p][i] = 0; me[p][i] = 0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq_o == '0, "R1 reset irq", 32'(irq_o), 0);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 3; s++) reg_op(p, s, 32'hFFFF_FFFF, 32'h0, "R1 reset read");

    // R2: identity 0 stays ineligible, lowest wins
    reg_op(0, 0, 32'h1, 32'h1, "R6 delivery write");
    bit_op(1, 0, 0, 0, 0);
    bit_op(1, 0, 0, 1, 0);
    reg_op(0, 2, 0, 0, "R2 id0 ignored");
    bit_op(1, 0, 5, 0, 0); bit_op(1, 0, 5, 1, 0);
    bit_op(1, 0, 3, 0, 0); bit_op(1, 0, 3, 1, 0);
    reg_op(0, 2, 0, 0, "R2 lowest wins");
    chk(irq_o[0] == 1'b1, "R7 irq high", 32'(irq_o[0]), 1);
    // R2: out-of-range identity ignored
    bit_op(1, 0, 45, 0, 0); bit_op(1, 0, 45, 1, 0);
    reg_op(0, 2, 0, 0, "R2 out of range id");

    // R3: threshold boundaries
    reg_op(0, 1, 32'd3, 32'hFFFF_FFFF, "R3 thr write");
    reg_op(0, 2, 0, 0, "R3 thr excludes equal");
    reg_op(0, 1, 32'd4, 32'hFFFF_FFFF, "R3 thr write");
    reg_op(0, 2, 0, 0, "R3 thr admits below");
    bit_op(0, 0, 3, 0, 0); bit_op(0, 0, 5, 0, 0);
    bit_op(1, 1, 39, 0, 0); bit_op(1, 1, 39, 1, 0);
    reg_op(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 delivery only bit0");
    reg_op(1, 1, 32'd39, 32'h7FF, "R3 thr write");
    reg_op(1, 2, 0, 0, "R3 thr 39");
    reg_op(1, 1, 32'd40, 32'h7FF, "R3 thr write");
    reg_op(1, 2, 0, 0, "R3 thr equals NUM_IDS");
    reg_op(1, 1, 32'd41, 32'h7FF, "R3 thr write");
    reg_op(1, 2, 0, 0, "R3 thr above NUM_IDS");
    reg_op(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 thr readback");
    reg_op(1, 1, 32'h0, 32'h0000_0700, "R6 thr masked merge");
    reg_op(1, 1, 32'h0, 32'h0, "R6 thr value");

    // R5: claim
    reg_op(1, 2, 32'h0, 32'h0, "R5 zero mask keeps");
    reg_op(1, 2, 32'h0, 32'h0, "R5 still pending");
    reg_op(1, 2, 32'h0, 32'h8000_0000, "R5 claim");
    reg_op(1, 2, 32'h0, 32'h0, "R5 cleared");
    reg_op(1, 2, 32'h1234, 32'hFFFF, "R5 claim nothing");

    // R9: set and clear collision
    bit_op(1, 2, 7, 0, 1); bit_op(1, 2, 7, 1, 1);
    reg_op(2, 0, 32'h1, 32'h1, "R8 page2 delivery");
    reg_op(2, 2, 0, 0, "R9 set wins");
    bit_op(0, 2, 7, 1, 0);
    reg_op(2, 2, 0, 0, "R9 enable cleared");

    // R8: missing page, pages independent
    reg_op(3, 0, 32'h1, 32'h1, "R8 bad page");
    reg_op(3, 2, 32'h0, 32'h1, "R8 bad page top");
    reg_op(0, 2, 0, 0, "R8 page0 unaffected");
    reg_op(0, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 sel3 zero");

    for (int n = 0; n < 1500; n++) begin
      int op = $urandom_range(99);
      int p = $urandom_range(NP - 1);
      int id = $urandom_range(NI + 3);
      logic [31:0] d = $urandom;
      logic [31:0] m = $urandom;
      if (op < 40)      bit_op(1, p, id, 0, 0);
      else if (op < 55) bit_op(1, p, id, 1, 0);
      else if (op < 65) bit_op(0, p, id, $urandom_range(1), 0);
      else if (op < 73) reg_op(p, 1, ($urandom_range(3) == 0) ? d : 32'($urandom_range(NI + 3)),
                               ($urandom_range(3) == 0) ? m : 32'hFFFF_FFFF, "R3 rand thr");
      else if (op < 78) reg_op(p, 0, d, m, "R6 rand delivery");
      else if (op < 92) reg_op(p, 2, d, (m == 0) ? 32'h1 : m, "R5 rand claim");
      else              bit_op(1, p, id, $urandom_range(1), 1);
      reg_op($urandom_range(NP - 1), 2, d, 32'h0, "R2 rand top");
    end
    report();
  end
endmodule